// File: doc/BRIEF.md
# Byte-Wide Parallel Port, Timer and Interrupt Register Unit

This block is a byte-wide register unit with sixteen registers behind a simple synchronous bus. A 4-bit register index, a read strobe, a write strobe and 8-bit write data select and update the registers. Read data is combinational from the index. Behind the bus are two 8-bit parallel ports, each with a direction register, an interrupt flag register, an interrupt enable register, a down-counting 16-bit timer, and plain holding registers for shift data, auxiliary control, peripheral control and the second timer's bytes.

Seven event inputs (two control lines per port, the shift register and two timers) set bits in the flag register. The internal timer also sets its own flag when its count borrows through zero. A registered, active-high interrupt output is high whenever a set flag is also enabled.

The timer is a three-state machine. `TM_IDLE` is the reset state, where the counter holds. `TM_RUN` counts down and can raise the flag. `TM_EXPIRED` keeps counting without raising the flag again. Transitions:
- `load` (write of the timer high byte): from any state to `TM_RUN`.
- `hit` (a tick while in `TM_RUN` with the count below the step size): `TM_RUN` to `TM_EXPIRED`.
- Any other cycle: the state stays as it is.

Register index map (the index order is part of the bus contract):

| Index | Register |
|---|---|
| 0 | port B |
| 1 | port A |
| 2 | port B direction |
| 3 | port A direction |
| 4 | timer-1 counter low |
| 5 | timer-1 counter high |
| 6 | timer-1 latch low |
| 7 | timer-1 latch high |
| 8 | timer-2 low |
| 9 | timer-2 high |
| 10 | shift holding |
| 11 | auxiliary control |
| 12 | peripheral control |
| 13 | flags |
| 14 | enables |
| 15 | port A alias |

Top module: `pio_irq_unit`

## Requirements
- R1: After reset every register reads zero (except bit 7 of index 14, see R4), `irq` is 0, and `pa_out`, `pa_dir`, `pb_out` and `pb_dir` are 0.
- R2: Reading index 1 returns `(ora & dira) | (pa_in & ~dira)`, where `ora` is the port A output register and `dira` is the port A direction register (1 = output). Index 0 does the same for port B with `orb`, `dirb` and `pb_in`. Index 15 reads and writes exactly as index 1.
- R3: `pa_out`/`pb_out` show the output registers written at index 1 (or 15) and index 0. `pa_dir`/`pb_dir` show the direction registers written at index 3 and index 2.
- R4: Writing index 14 with data bit 7 = 1 sets the enable bits given in data[6:0]; with bit 7 = 0 it clears them. Reading index 14 returns {1, enables[6:0]}.
- R5: Writing index 13 clears each flag whose data bit is 1. Reading index 13 returns flags[6:0], with bit 7 = 1 when any flag is both set and enabled.
- R6: Flag bits: bit0 CA2, bit1 CA1, bit2 shift, bit3 CB2, bit4 CB1, bit5 timer 2, bit6 timer 1. A one-cycle pulse on `evt[i]` sets flag i whether or not it is enabled. A set and a clear of the same flag in the same cycle leaves it set.
- R7: `irq` is a register. After each clock edge it equals the OR of (flags & enables) over bits 6:0. It therefore rises on the edge of an enable write that matches an already-set flag.
- R8: Writing index 8 stores a low latch byte and does not start the timer. Writing index 9 loads the counter with {data, low latch}, clears flag 5 and starts counting. Index 9 reads counter[15:8] and index 8 reads counter[7:0].
- R9: While started, each cycle with `tick` = 1 lowers the counter by 2 (modulo 2^16). Without `tick`, or before the first load, the counter holds.
- R10: A tick in the counting state with the counter at 0 or 1 sets flag 5 once. Later ticks keep counting but do not set flag 5 again until the next load at index 9.
- R11: Reading index 8 clears flag 5. Reading index 4 or writing index 5 clears flag 6.
- R12: Indexes 10, 11 and 12 read back the last byte written to them. Writes to index 4 or 6 set the timer-1 low byte and writes to 5 or 7 set the timer-1 high byte; indexes 4 and 6 read the low byte and indexes 5 and 7 read the high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| sel | input | 4 | register index |
| rd_en | input | 1 | read strobe; read side effects occur at the clock edge |
| wr_en | input | 1 | write strobe |
| wdata | input | 8 | write data |
| rdata | output | 8 | read data for `sel` (combinational) |
| tick | input | 1 | timer count enable |
| evt | input | 7 | flag-setting event pulses, bit order as the flags |
| pa_in | input | 8 | port A pin inputs |
| pa_out | output | 8 | port A output register |
| pa_dir | output | 8 | port A direction (1 = output) |
| pb_in | input | 8 | port B pin inputs |
| pb_out | output | 8 | port B output register |
| pb_dir | output | 8 | port B direction (1 = output) |
| irq | output | 1 | registered interrupt request |

## Verification
The embedded assertions check on every cycle that `irq` agrees with the stored flags and enables. They also check that an event pulse always lands in the flags, that enable writes set or clear exactly the given bits, and that a flag write clears the given bits. On the timer side they check the step of two per tick, that the counter holds without a tick, and that no flag is raised from the expired state. Only the bench scenarios show the values returned on the bus: the port mixing, the alias at index 15, the read-to-acknowledge side effects, the exact tick on which the timer borrows, and the holding registers.

// File: rtl/pio_pkg.sv
package pio_pkg;
    localparam int unsigned NFLAG = 7;

    typedef enum logic [3:0] {
        IX_PB      = 4'd0,
        IX_PA      = 4'd1,
        IX_DIRB    = 4'd2,
        IX_DIRA    = 4'd3,
        IX_T1_CLO  = 4'd4,
        IX_T1_CHI  = 4'd5,
        IX_T1_LLO  = 4'd6,
        IX_T1_LHI  = 4'd7,
        IX_T2_LO   = 4'd8,
        IX_T2_HI   = 4'd9,
        IX_SHIFT   = 4'd10,
        IX_AUXC    = 4'd11,
        IX_PERC    = 4'd12,
        IX_FLAGS   = 4'd13,
        IX_ENAB    = 4'd14,
        IX_PA_ALT  = 4'd15
    } reg_idx_e;

    localparam int unsigned FB_CA2   = 0;
    localparam int unsigned FB_CA1   = 1;
    localparam int unsigned FB_SHIFT = 2;
    localparam int unsigned FB_CB2   = 3;
    localparam int unsigned FB_CB1   = 4;
    localparam int unsigned FB_T2    = 5;
    localparam int unsigned FB_T1    = 6;

    typedef enum logic [1:0] {
        TM_IDLE    = 2'd0,
        TM_RUN     = 2'd1,
        TM_EXPIRED = 2'd2
    } tmr_state_e;
endpackage

// File: rtl/pio_port.sv
module pio_port #(
    parameter int unsigned PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_out,
    input  logic          wr_dir,
    input  logic [PW-1:0] wdata,
    input  logic [PW-1:0] pin_in,
    output logic [PW-1:0] out_q,
    output logic [PW-1:0] dir_q,
    output logic [PW-1:0] rd_val
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
            dir_q <= '0;
        end else begin
            if (wr_out) out_q <= wdata;
            if (wr_dir) dir_q <= wdata;
        end
    end

    // each bit: driven value when output, pin value when input
    always_comb begin
        for (int b = 0; b < int'(PW); b++) begin
            rd_val[b] = dir_q[b] ? out_q[b] : pin_in[b];
        end
    end

    // R3: a write to the output register is visible on the pins next cycle
    assert_out_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_out |=> out_q == $past(wdata));
endmodule

// File: rtl/pio_timer.sv
module pio_timer #(
    parameter int unsigned BW   = 8,
    parameter int unsigned STEP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BW-1:0]     wdata,
    output logic [2*BW-1:0]   cnt,
    output logic              hit
);
    import pio_pkg::*;
    localparam int unsigned TW = 2 * BW;
    localparam logic [TW-1:0] STEP_V = TW'(STEP);

    tmr_state_e      state_q, state_d;
    logic [TW-1:0]   cnt_q, cnt_d;
    logic [BW-1:0]   lo_q;
    logic            borrow;

    assign borrow = cnt_q < STEP_V;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TM_IDLE;
            cnt_q   <= '0;
            lo_q    <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (wr_lo) lo_q <= wdata;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        hit     = 1'b0;
        if (wr_hi) begin
            cnt_d   = {wdata, lo_q};
            state_d = TM_RUN;
        end else begin
            unique case (state_q)
                TM_IDLE: begin
                    cnt_d = cnt_q;
                end
                TM_RUN: begin
                    if (tick) begin
                        cnt_d = cnt_q - STEP_V;
                        if (borrow) begin
                            hit     = 1'b1;
                            state_d = TM_EXPIRED;
                        end
                    end
                end
                TM_EXPIRED: begin
                    if (tick) cnt_d = cnt_q - STEP_V;
                end
                default: state_d = TM_IDLE;
            endcase
        end
    end

    assign cnt = cnt_q;

    // R9: a tick while started steps the count down by the step size
    assert_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_hi && state_q != TM_IDLE) |=> cnt_q == $past(cnt_q) - STEP_V);
    // R9: no tick and no load leaves the count unchanged
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_hi) |=> $stable(cnt_q));
    // R10: the expired state never raises the flag
    assert_single_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TM_EXPIRED) |-> !hit);
endmodule

// File: rtl/pio_irq_ctrl.sv
module pio_irq_ctrl #(
    parameter int unsigned NF = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set_evt,
    input  logic [NF-1:0] clr,
    input  logic          ier_wr,
    input  logic          ier_mode,
    input  logic [NF-1:0] ier_bits,
    output logic [NF-1:0] ifr_q,
    output logic [NF-1:0] ier_q,
    output logic          irq
);
    logic [NF-1:0] ifr_d, ier_d;

    always_comb begin
        ifr_d = (ifr_q & ~clr) | set_evt;
        ier_d = ier_q;
        if (ier_wr) ier_d = ier_mode ? (ier_q | ier_bits) : (ier_q & ~ier_bits);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ifr_q <= '0;
            ier_q <= '0;
            irq   <= 1'b0;
        end else begin
            ifr_q <= ifr_d;
            ier_q <= ier_d;
            irq   <= |(ifr_d & ier_d);
        end
    end

    // R7: the output agrees with the stored flags and enables
    assert_irq_summary_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(ifr_q & ier_q));
    // R6: every event pulse lands in the flags
    assert_event_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_evt) |=> (ifr_q & $past(set_evt)) == $past(set_evt));
    // R4: enable writes set or clear exactly the given bits
    assert_ier_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_wr && ier_mode) |=> (ier_q & $past(ier_bits)) == $past(ier_bits));
    assert_ier_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_wr && !ier_mode) |=> (ier_q & $past(ier_bits)) == '0);
    // R5: a clear request removes the flag unless an event sets it again
    assert_flag_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr) |=> (ifr_q & $past(clr & ~set_evt)) == '0);
endmodule

// File: rtl/pio_irq_unit.sv
module pio_irq_unit #(
    parameter int unsigned PW   = 8,
    parameter int unsigned STEP = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    sel,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata,
    input  logic          tick,
    input  logic [6:0]    evt,
    input  logic [PW-1:0] pa_in,
    output logic [PW-1:0] pa_out,
    output logic [PW-1:0] pa_dir,
    input  logic [PW-1:0] pb_in,
    output logic [PW-1:0] pb_out,
    output logic [PW-1:0] pb_dir,
    output logic          irq
);
    import pio_pkg::*;
    localparam int unsigned BW = 8;
    localparam int unsigned NF = NFLAG;

    reg_idx_e      idx;
    logic [15:0]   wsel, rsel;
    logic [PW-1:0] pa_rd, pb_rd;
    logic [15:0]   t2_cnt;
    logic          t2_hit;
    logic [NF-1:0] ifr, ier, set_all, clr_all;
    logic [BW-1:0] t1_lo_q, t1_hi_q, sh_q, auxc_q, perc_q;

    assign idx = reg_idx_e'(sel);

    // one-hot strobes per register index
    generate
        for (genvar i = 0; i < 16; i++) begin : g_dec
            assign wsel[i] = wr_en && (sel == 4'(i));
            assign rsel[i] = rd_en && (sel == 4'(i));
        end
    endgenerate

    pio_port #(.PW(PW)) u_port_a (
        .clk(clk), .rst_n(rst_n),
        .wr_out(wsel[IX_PA] | wsel[IX_PA_ALT]), .wr_dir(wsel[IX_DIRA]),
        .wdata(wdata[PW-1:0]), .pin_in(pa_in),
        .out_q(pa_out), .dir_q(pa_dir), .rd_val(pa_rd)
    );

    pio_port #(.PW(PW)) u_port_b (
        .clk(clk), .rst_n(rst_n),
        .wr_out(wsel[IX_PB]), .wr_dir(wsel[IX_DIRB]),
        .wdata(wdata[PW-1:0]), .pin_in(pb_in),
        .out_q(pb_out), .dir_q(pb_dir), .rd_val(pb_rd)
    );

    pio_timer #(.BW(BW), .STEP(STEP)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .wr_lo(wsel[IX_T2_LO]), .wr_hi(wsel[IX_T2_HI]),
        .wdata(wdata), .cnt(t2_cnt), .hit(t2_hit)
    );

    always_comb begin
        set_all = evt;
        set_all[FB_T2] = evt[FB_T2] | t2_hit;
        clr_all = wsel[IX_FLAGS] ? wdata[NF-1:0] : '0;
        if (rsel[IX_T2_LO] || wsel[IX_T2_HI])  clr_all[FB_T2] = 1'b1;
        if (rsel[IX_T1_CLO] || wsel[IX_T1_CHI]) clr_all[FB_T1] = 1'b1;
    end

    pio_irq_ctrl #(.NF(NF)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .set_evt(set_all), .clr(clr_all),
        .ier_wr(wsel[IX_ENAB]), .ier_mode(wdata[7]), .ier_bits(wdata[NF-1:0]),
        .ifr_q(ifr), .ier_q(ier), .irq(irq)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t1_lo_q <= '0;
            t1_hi_q <= '0;
            sh_q    <= '0;
            auxc_q  <= '0;
            perc_q  <= '0;
        end else begin
            if (wsel[IX_T1_CLO] || wsel[IX_T1_LLO]) t1_lo_q <= wdata;
            if (wsel[IX_T1_CHI] || wsel[IX_T1_LHI]) t1_hi_q <= wdata;
            if (wsel[IX_SHIFT]) sh_q   <= wdata;
            if (wsel[IX_AUXC])  auxc_q <= wdata;
            if (wsel[IX_PERC])  perc_q <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (idx)
            IX_PB:                 rdata = 8'(pb_rd);
            IX_PA, IX_PA_ALT:      rdata = 8'(pa_rd);
            IX_DIRB:               rdata = 8'(pb_dir);
            IX_DIRA:               rdata = 8'(pa_dir);
            IX_T1_CLO, IX_T1_LLO:  rdata = t1_lo_q;
            IX_T1_CHI, IX_T1_LHI:  rdata = t1_hi_q;
            IX_T2_LO:              rdata = t2_cnt[7:0];
            IX_T2_HI:              rdata = t2_cnt[15:8];
            IX_SHIFT:              rdata = sh_q;
            IX_AUXC:               rdata = auxc_q;
            IX_PERC:               rdata = perc_q;
            IX_FLAGS:              rdata = {|(ifr & ier), ifr};
            IX_ENAB:               rdata = {1'b1, ier};
            default:               rdata = '0;
        endcase
    end

    // R11: reading the timer-2 low byte acknowledges its flag (no event that cycle)
    assert_t2_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsel[IX_T2_LO] && !evt[FB_T2] && !t2_hit) |=> !ifr[FB_T2]);
endmodule

// File: tb/pio_irq_unit_tb.sv
module pio_irq_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] sel = '0;
    logic       rd_en = 1'b0, wr_en = 1'b0, tick = 1'b0;
    logic [7:0] wdata = '0, rdata;
    logic [6:0] evt = '0;
    logic [7:0] pa_in = '0, pb_in = '0, pa_out, pa_dir, pb_out, pb_dir;
    logic       irq;
    int n_run = 0, n_fail = 0;
    logic [7:0] v;

    always #5 clk = ~clk;

    pio_irq_unit u_dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .tick(tick), .evt(evt),
        .pa_in(pa_in), .pa_out(pa_out), .pa_dir(pa_dir),
        .pb_in(pb_in), .pb_out(pb_out), .pb_dir(pb_dir), .irq(irq)
    );

    task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(logic [3:0] i, logic [7:0] d);
        @(negedge clk); sel = i; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(logic [3:0] i, output logic [7:0] d);
        @(negedge clk); sel = i; rd_en = 1'b1; #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic pulse(logic [6:0] e);
        @(negedge clk); evt = e;
        @(negedge clk); evt = '0;
    endtask

    task automatic t_reset;
        chk("R1 irq", irq, 0);
        chk("R1 pins", {pa_out, pa_dir, pb_out, pb_dir} == 0, 1);
        rd(4'd13, v); chk("R1 flags", v, 8'h00);
        rd(4'd14, v); chk("R1 enables", v, 8'h80);
        rd(4'd9, v);  chk("R1 timer hi", v, 8'h00);
        rd(4'd11, v); chk("R1 aux", v, 8'h00);
    endtask

    task automatic t_ports;
        wr(4'd3, 8'hF0); wr(4'd1, 8'hA5); pa_in = 8'h3C;
        chk("R3 pa_dir", pa_dir, 8'hF0);
        chk("R3 pa_out", pa_out, 8'hA5);
        rd(4'd1, v);  chk("R2 port A mix", v, 8'hAC);
        rd(4'd15, v); chk("R2 alias read", v, 8'hAC);
        wr(4'd15, 8'h5A);
        chk("R2 alias write pin", pa_out, 8'h5A);
        rd(4'd1, v);  chk("R2 port A after alias", v, 8'h5C);
        wr(4'd2, 8'h0F); wr(4'd0, 8'h33); pb_in = 8'hC0;
        chk("R3 pb_out", pb_out, 8'h33);
        chk("R3 pb_dir", pb_dir, 8'h0F);
        rd(4'd0, v);  chk("R2 port B mix", v, 8'hC3);
    endtask

    task automatic t_flags_irq;
        pulse(7'h09);
        rd(4'd13, v); chk("R6 flags unenabled", v, 8'h09);
        chk("R7 irq low, nothing enabled", irq, 0);
        wr(4'd14, 8'h88);
        chk("R7 irq on enable of set flag", irq, 1);
        rd(4'd14, v); chk("R4 enable set", v, 8'h88);
        rd(4'd13, v); chk("R5 summary bit", v, 8'h89);
        wr(4'd14, 8'h08);
        chk("R7 irq drop on disable", irq, 0);
        rd(4'd14, v); chk("R4 enable clear", v, 8'h80);
        wr(4'd13, 8'h08);
        rd(4'd13, v); chk("R5 write-one clear", v, 8'h01);
        // set and clear of bit0 in the same cycle
        @(negedge clk); sel = 4'd13; wdata = 8'h01; wr_en = 1'b1; evt = 7'h01;
        @(negedge clk); wr_en = 1'b0; evt = '0;
        rd(4'd13, v); chk("R6 set wins over clear", v, 8'h01);
        wr(4'd13, 8'h7F);
        rd(4'd13, v); chk("R5 clear all", v, 8'h00);
    endtask

    task automatic t_timer;
        wr(4'd8, 8'h05);
        ticks(2);
        rd(4'd8, v); chk("R8 low write does not start", v, 8'h00);
        wr(4'd9, 8'h00);
        rd(4'd8, v); chk("R8 loaded low", v, 8'h05);
        rd(4'd9, v); chk("R8 loaded high", v, 8'h00);
        @(negedge clk); @(negedge clk);
        rd(4'd8, v); chk("R9 hold without tick", v, 8'h05);
        ticks(2);
        rd(4'd8, v); chk("R9 step of two", v, 8'h01);
        rd(4'd13, v); chk("R10 no flag before borrow", v, 8'h00);
        ticks(1);
        rd(4'd13, v); chk("R10 flag on borrow", v, 8'h20);
        rd(4'd9, v); chk("R9 wrap high", v, 8'hFF);
        wr(4'd14, 8'hA0);
        chk("R7 irq from timer flag", irq, 1);
        rd(4'd8, v); chk("R9 wrap low", v, 8'hFF);
        rd(4'd13, v); chk("R11 low read acks timer-2", v, 8'h00);
        chk("R11 irq drops after ack", irq, 0);
        ticks(3);
        rd(4'd13, v); chk("R10 no second flag", v, 8'h00);
        pulse(7'h20);
        wr(4'd9, 8'h00);
        rd(4'd13, v); chk("R8 load clears flag 5", v, 8'h00);
        ticks(3);
        rd(4'd13, v); chk("R10 flag after reload", v, 8'hA0);
        wr(4'd14, 8'h20);
    endtask

    task automatic t_t1_and_store;
        pulse(7'h40);
        rd(4'd4, v);
        rd(4'd13, v); chk("R11 read idx4 acks timer-1", v & 8'h40, 8'h00);
        pulse(7'h40);
        wr(4'd5, 8'h12);
        rd(4'd13, v); chk("R11 write idx5 acks timer-1", v & 8'h40, 8'h00);
        wr(4'd6, 8'h34);
        rd(4'd4, v); chk("R12 t1 low", v, 8'h34);
        rd(4'd7, v); chk("R12 t1 high", v, 8'h12);
        wr(4'd10, 8'h9C); wr(4'd11, 8'h61); wr(4'd12, 8'hE7);
        rd(4'd10, v); chk("R12 shift", v, 8'h9C);
        rd(4'd11, v); chk("R12 aux", v, 8'h61);
        rd(4'd12, v); chk("R12 perc", v, 8'hE7);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ports();
        t_flags_irq();
        t_timer();
        t_t1_and_store();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule